// File: doc/BRIEF.md
# Single-Cycle RISC Control Decoder

This block is the control decoder of a 32-bit single-cycle RISC datapath. It is purely combinational. From the six opcode bits of the current instruction (instruction bits 31:26), the zero flag produced by the register-compare path, an interrupt request and an externally raised illegal-instruction flag, it produces every select and enable the datapath needs in the same cycle. These are the ALU function, the register-file write enable, the B-operand literal select, the write-back source, the memory write enable, the second-read-port address select, the next-PC source, the A-operand PC select and the write-address exception-register select.

The decoder recognises register ALU operations, ALU operations with a sign-extended literal, load, store, register jump, branch-if-equal, branch-if-not-equal, PC-relative load, illegal opcodes and interrupts. Traps share the one decode table with ordinary instructions. A trap takes its own PC source and forces the write address onto the exception-pointer register, so that the register file captures PC+4. A pending interrupt outranks everything else. Any trap holds the memory write enable low.

Top module: `risc_ctrl_decoder`

## Requirements
- R1: Opcode classes are: 0x18 load, 0x19 store, 0x1B jump, 0x1C branch-if-equal, 0x1D branch-if-not-equal, 0x1F PC-relative load, 0x20–0x2F register ALU, 0x30–0x3F literal ALU. Every other opcode is illegal.
- R2: A register ALU op drives alu_fn with opcode bits 3:0 (zero-extended to FN_W). It sets rf_we=1 and wb_src=1 (ALU result), and sets b_lit_sel, mem_we, rd2_rc_sel, pc_src, a_pc_sel and wa_xp_sel to 0.
- R3: A literal ALU op drives the same outputs as R2, except that b_lit_sel=1.
- R4: A load gives alu_fn=FN_ADD (default 0x0), b_lit_sel=1, wb_src=2 (memory data) and rf_we=1. It sets mem_we, rd2_rc_sel, a_pc_sel and wa_xp_sel to 0 and pc_src to 0 (PC+4).
- R5: A store gives alu_fn=FN_ADD, rf_we=0, b_lit_sel=1, mem_we=1 and rd2_rc_sel=1. It sets wb_src, pc_src, a_pc_sel and wa_xp_sel to 0.
- R6: A jump gives rf_we=1, wb_src=0 (PC+4), pc_src=2 (register target) and alu_fn=FN_ADD. All other selects are 0.
- R7: Both branches give rf_we=1, wb_src=0 and alu_fn=FN_ADD, with all other selects 0 except pc_src. pc_src=1 (branch target) when branch-if-equal sees cmp_zero=1 or branch-if-not-equal sees cmp_zero=0; otherwise pc_src=0.
- R8: A PC-relative load gives alu_fn=FN_PASS_A (default 0xA), a_pc_sel=1, wb_src=2 and rf_we=1. It sets b_lit_sel, mem_we, rd2_rc_sel, pc_src and wa_xp_sel to 0.
- R9: An illegal opcode, or ill_flag=1 with any opcode, gives pc_src=3, wa_xp_sel=1, wb_src=0, rf_we=1, mem_we=0 and alu_fn=FN_ADD. All other selects are 0.
- R10: irq_req=1 gives pc_src=4, wa_xp_sel=1, wb_src=0, rf_we=1, mem_we=0 and alu_fn=FN_ADD, with all other selects 0. This holds whatever the opcode, ill_flag and cmp_zero are.
- R11: cmp_zero has no effect on any output unless the instruction is a branch and no trap is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Opcode field, instruction bits 31:26 |
| cmp_zero | input | 1 | Register-compare result is zero |
| irq_req | input | 1 | Interrupt request |
| ill_flag | input | 1 | External illegal-instruction indication |
| alu_fn | output | FN_W | ALU function code |
| rf_we | output | 1 | Register-file write enable |
| b_lit_sel | output | 1 | ALU B takes the sign-extended literal |
| wb_src | output | 2 | Write-back source: 0 PC+4, 1 ALU, 2 memory |
| mem_we | output | 1 | Data-memory write enable |
| rd2_rc_sel | output | 1 | Second read port addresses the destination field |
| pc_src | output | 3 | Next PC: 0 PC+4, 1 branch, 2 jump, 3 illegal trap, 4 interrupt |
| a_pc_sel | output | 1 | ALU A takes the PC-relative address |
| wa_xp_sel | output | 1 | Write address forced to the exception pointer |

## Verification
The bench keeps the default parameters: a 4-bit ALU function field, an add code of 0x0 and a pass-A code of 0xA. With these values the whole input space fits in 512 vectors: every 6-bit opcode, crossed with both values of the zero flag, the interrupt request and the external illegal flag. The sweep therefore reaches every class boundary, every opcode taken as an ALU function, and every pairing of trap priority with branch polarity.

// File: rtl/rcd_pkg.sv
// Package rcd_pkg
// Shared opcode values, instruction classes and control encodings for the
// control decoder. Assumes a 6-bit opcode taken from instruction bits 31:26.
package rcd_pkg;

    localparam int OP_W   = 6;
    localparam int WB_W   = 2;
    localparam int PCS_W  = 3;

    localparam logic [OP_W-1:0] OPC_LOAD   = 6'h18;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'h19;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'h1B;
    localparam logic [OP_W-1:0] OPC_BR_EQ  = 6'h1C;
    localparam logic [OP_W-1:0] OPC_BR_NE  = 6'h1D;
    localparam logic [OP_W-1:0] OPC_LD_REL = 6'h1F;
    localparam logic [1:0]      OPC_ALU_HI = 2'b10;   // op[5:4] of register ALU ops
    localparam logic [1:0]      OPC_LIT_HI = 2'b11;   // op[5:4] of literal ALU ops

    typedef enum logic [3:0] {
        CL_ALU_REG,
        CL_ALU_LIT,
        CL_LOAD,
        CL_STORE,
        CL_JUMP,
        CL_BR_EQ,
        CL_BR_NE,
        CL_LD_REL,
        CL_ILLEGAL,
        CL_IRQ
    } instr_class_e;

    typedef enum logic [WB_W-1:0] {
        WB_PC4 = 2'd0,
        WB_ALU = 2'd1,
        WB_MEM = 2'd2
    } wb_src_e;

    typedef enum logic [PCS_W-1:0] {
        PCS_NEXT   = 3'd0,
        PCS_BRANCH = 3'd1,
        PCS_JUMP   = 3'd2,
        PCS_ILLOP  = 3'd3,
        PCS_IRQ    = 3'd4
    } pc_src_e;

    // Static part of the control vector (everything except the PC source
    // and the final ALU code).
    typedef struct packed {
        logic    rf_we;
        logic    b_lit;
        wb_src_e wb;
        logic    mem_we;
        logic    rd2_rc;
        logic    a_pc;
        logic    wa_xp;
        logic    fn_from_op;
        logic    fn_pass_a;
    } ctrl_t;

    // True for the two classes that redirect into a handler.
    function automatic logic is_trap(input instr_class_e c);
        return (c == CL_ILLEGAL) || (c == CL_IRQ);
    endfunction

endpackage

// File: rtl/rcd_classify.sv
// Module rcd_classify
// Maps the opcode and the trap inputs onto one instruction class.
// Priority: interrupt, then external illegal flag, then opcode decode.
// Assumes the opcode map of rcd_pkg; any unlisted opcode is illegal.
module rcd_classify
    import rcd_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    input  logic            irq_req,
    input  logic            ill_flag,
    output instr_class_e    cls
);

    instr_class_e op_cls;

    // Decode the opcode alone, with no trap context.
    always_comb begin
        op_cls = CL_ILLEGAL;
        if (op_code[5:4] == OPC_ALU_HI) begin
            op_cls = CL_ALU_REG;
        end else if (op_code[5:4] == OPC_LIT_HI) begin
            op_cls = CL_ALU_LIT;
        end else begin
            case (op_code)
                OPC_LOAD:   op_cls = CL_LOAD;
                OPC_STORE:  op_cls = CL_STORE;
                OPC_JUMP:   op_cls = CL_JUMP;
                OPC_BR_EQ:  op_cls = CL_BR_EQ;
                OPC_BR_NE:  op_cls = CL_BR_NE;
                OPC_LD_REL: op_cls = CL_LD_REL;
                default:    op_cls = CL_ILLEGAL;
            endcase
        end
    end

    // Apply trap priority on top of the opcode class.
    always_comb begin
        if (irq_req)       cls = CL_IRQ;
        else if (ill_flag) cls = CL_ILLEGAL;
        else               cls = op_cls;
    end

endmodule

// File: rtl/rcd_ctrl_table.sv
// Module rcd_ctrl_table
// Static control table: one row per instruction class, giving every
// select except the PC source. Assumes cls is already trap-resolved.
module rcd_ctrl_table
    import rcd_pkg::*;
(
    input  instr_class_e cls,
    output ctrl_t        ctrl
);

    // Look up the control row for the resolved class.
    always_comb begin
        ctrl = '{rf_we: 1'b0, b_lit: 1'b0, wb: WB_PC4, mem_we: 1'b0,
                 rd2_rc: 1'b0, a_pc: 1'b0, wa_xp: 1'b0,
                 fn_from_op: 1'b0, fn_pass_a: 1'b0};
        case (cls)
            CL_ALU_REG: begin
                ctrl.rf_we      = 1'b1;
                ctrl.wb         = WB_ALU;
                ctrl.fn_from_op = 1'b1;
            end
            CL_ALU_LIT: begin
                ctrl.rf_we      = 1'b1;
                ctrl.wb         = WB_ALU;
                ctrl.b_lit      = 1'b1;
                ctrl.fn_from_op = 1'b1;
            end
            CL_LOAD: begin
                ctrl.rf_we = 1'b1;
                ctrl.b_lit = 1'b1;
                ctrl.wb    = WB_MEM;
            end
            CL_STORE: begin
                ctrl.b_lit  = 1'b1;
                ctrl.mem_we = 1'b1;
                ctrl.rd2_rc = 1'b1;
            end
            CL_JUMP, CL_BR_EQ, CL_BR_NE: begin
                ctrl.rf_we = 1'b1;
                ctrl.wb    = WB_PC4;
            end
            CL_LD_REL: begin
                ctrl.rf_we     = 1'b1;
                ctrl.wb        = WB_MEM;
                ctrl.a_pc      = 1'b1;
                ctrl.fn_pass_a = 1'b1;
            end
            CL_ILLEGAL, CL_IRQ: begin
                ctrl.rf_we = 1'b1;
                ctrl.wb    = WB_PC4;
                ctrl.wa_xp = 1'b1;
            end
            default: begin
                ctrl.rf_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rcd_pc_select.sv
// Module rcd_pc_select
// Chooses the next-PC source from the class and the compare flag.
// Assumes cls is trap-resolved; cmp_zero only matters for branches.
module rcd_pc_select
    import rcd_pkg::*;
(
    input  instr_class_e cls,
    input  logic         cmp_zero,
    output pc_src_e      pc_src
);

    // Resolve branch polarity and trap vectors into one PC source.
    always_comb begin
        case (cls)
            CL_JUMP:    pc_src = PCS_JUMP;
            CL_BR_EQ:   pc_src = cmp_zero ? PCS_BRANCH : PCS_NEXT;
            CL_BR_NE:   pc_src = cmp_zero ? PCS_NEXT : PCS_BRANCH;
            CL_ILLEGAL: pc_src = PCS_ILLOP;
            CL_IRQ:     pc_src = PCS_IRQ;
            default:    pc_src = PCS_NEXT;
        endcase
    end

endmodule

// File: rtl/rcd_fn_select.sv
// Module rcd_fn_select
// Builds the ALU function code: opcode bits 3:0 for ALU classes, the
// pass-A code for the PC-relative load, the add code otherwise.
// Assumes FN_W >= 1; opcode bits are zero-extended or truncated to FN_W.
module rcd_fn_select #(
    parameter int             FN_W      = 4,
    parameter logic [FN_W-1:0] FN_ADD    = '0,
    parameter logic [FN_W-1:0] FN_PASS_A = FN_W'(4'hA)
) (
    input  logic [3:0]      op_lo,
    input  logic            fn_from_op,
    input  logic            fn_pass_a,
    output logic [FN_W-1:0] alu_fn
);

    localparam int OP_FN_W = 4;

    logic [FN_W-1:0] op_fn;

    // Fit the opcode function bits to the configured ALU code width.
    generate
        if (FN_W == OP_FN_W) begin : g_same
            assign op_fn = op_lo;
        end else if (FN_W > OP_FN_W) begin : g_wide
            assign op_fn = {{(FN_W-OP_FN_W){1'b0}}, op_lo};
        end else begin : g_narrow
            assign op_fn = op_lo[FN_W-1:0];
        end
    endgenerate

    // Pick the ALU function source.
    always_comb begin
        if (fn_from_op)     alu_fn = op_fn;
        else if (fn_pass_a) alu_fn = FN_PASS_A;
        else                alu_fn = FN_ADD;
    end

endmodule

// File: rtl/risc_ctrl_decoder.sv
// Module risc_ctrl_decoder
// Combinational control decoder for a single-cycle 32-bit RISC datapath.
// It classifies the opcode, looks up the static controls, resolves the PC
// source and gates the memory write on traps. It has no state and needs no
// clock or reset; its outputs are valid once the inputs settle.
module risc_ctrl_decoder
    import rcd_pkg::*;
#(
    parameter int              FN_W      = 4,
    parameter logic [FN_W-1:0] FN_ADD    = '0,
    parameter logic [FN_W-1:0] FN_PASS_A = FN_W'(4'hA)
) (
    input  logic [5:0]      op_code,
    input  logic            cmp_zero,
    input  logic            irq_req,
    input  logic            ill_flag,
    output logic [FN_W-1:0] alu_fn,
    output logic            rf_we,
    output logic            b_lit_sel,
    output logic [1:0]      wb_src,
    output logic            mem_we,
    output logic            rd2_rc_sel,
    output logic [2:0]      pc_src,
    output logic            a_pc_sel,
    output logic            wa_xp_sel
);

    instr_class_e cls;
    ctrl_t        ctrl;
    pc_src_e      pcs;
    logic         trap;

    rcd_classify u_classify (
        .op_code  (op_code),
        .irq_req  (irq_req),
        .ill_flag (ill_flag),
        .cls      (cls)
    );

    rcd_ctrl_table u_table (
        .cls  (cls),
        .ctrl (ctrl)
    );

    rcd_pc_select u_pcsel (
        .cls      (cls),
        .cmp_zero (cmp_zero),
        .pc_src   (pcs)
    );

    rcd_fn_select #(
        .FN_W      (FN_W),
        .FN_ADD    (FN_ADD),
        .FN_PASS_A (FN_PASS_A)
    ) u_fn (
        .op_lo      (op_code[3:0]),
        .fn_from_op (ctrl.fn_from_op),
        .fn_pass_a  (ctrl.fn_pass_a),
        .alu_fn     (alu_fn)
    );

    // Trap guard: no memory write may escape while a trap is taken.
    assign trap = is_trap(cls);

    // Drive the port-level controls from the resolved rows.
    always_comb begin
        rf_we      = ctrl.rf_we;
        b_lit_sel  = ctrl.b_lit;
        wb_src     = ctrl.wb;
        mem_we     = ctrl.mem_we & ~trap;
        rd2_rc_sel = ctrl.rd2_rc;
        pc_src     = pcs;
        a_pc_sel   = ctrl.a_pc;
        wa_xp_sel  = ctrl.wa_xp;
    end

endmodule

// File: rtl/risc_ctrl_decoder_chk.sv
// Module risc_ctrl_decoder_chk
// Port-level consistency checks for the control decoder, bound to every
// instance. Immediate checks only, since the block has no clock.
module risc_ctrl_decoder_chk #(
    parameter int              FN_W      = 4,
    parameter logic [FN_W-1:0] FN_PASS_A = FN_W'(4'hA)
) (
    input logic [5:0]      op_code,
    input logic            cmp_zero,
    input logic            irq_req,
    input logic            ill_flag,
    input logic [FN_W-1:0] alu_fn,
    input logic            rf_we,
    input logic            b_lit_sel,
    input logic [1:0]      wb_src,
    input logic            mem_we,
    input logic            rd2_rc_sel,
    input logic [2:0]      pc_src,
    input logic            a_pc_sel,
    input logic            wa_xp_sel
);

    logic is_branch_op;
    assign is_branch_op = (op_code == 6'h1C) || (op_code == 6'h1D);

    // Check trap, store, branch and PC-relative invariants at the ports.
    always_comb begin
        if (irq_req) begin
            p_irq_wins_r10: assert (pc_src == 3'd4 && wa_xp_sel && rf_we && !mem_we)
                else $error("interrupt did not take priority");
        end
        if (!irq_req && ill_flag) begin
            p_ill_trap_r9: assert (pc_src == 3'd3 && wa_xp_sel && !mem_we)
                else $error("illegal flag did not trap");
        end
        p_xp_on_trap_r9: assert (wa_xp_sel == (pc_src == 3'd3 || pc_src == 3'd4))
            else $error("exception-pointer select out of step with trap PC");
        if (mem_we) begin
            p_store_shape_r5: assert (!rf_we && rd2_rc_sel && b_lit_sel && op_code == 6'h19)
                else $error("memory write outside a store");
        end
        if (pc_src == 3'd1) begin
            p_branch_taken_r7: assert (is_branch_op && !irq_req && !ill_flag)
                else $error("branch target chosen outside a branch");
        end
        if (a_pc_sel) begin
            p_pcrel_load_r8: assert (wb_src == 2'd2 && alu_fn == FN_PASS_A && rf_we)
                else $error("PC-relative operand without PC-relative load");
        end
    end

endmodule

bind risc_ctrl_decoder risc_ctrl_decoder_chk #(
    .FN_W      (FN_W),
    .FN_PASS_A (FN_PASS_A)
) u_chk (
    .op_code    (op_code),
    .cmp_zero   (cmp_zero),
    .irq_req    (irq_req),
    .ill_flag   (ill_flag),
    .alu_fn     (alu_fn),
    .rf_we      (rf_we),
    .b_lit_sel  (b_lit_sel),
    .wb_src     (wb_src),
    .mem_we     (mem_we),
    .rd2_rc_sel (rd2_rc_sel),
    .pc_src     (pc_src),
    .a_pc_sel   (a_pc_sel),
    .wa_xp_sel  (wa_xp_sel)
);

// File: tb/risc_ctrl_decoder_bench.sv
// Bench risc_ctrl_decoder_bench
// Exhaustive sweep of opcode x cmp_zero x irq_req x ill_flag against a
// control vector computed from the requirements.
module risc_ctrl_decoder_bench;

    localparam int         FN_W  = 4;
    localparam logic [3:0] E_ADD = 4'h0;
    localparam logic [3:0] E_PSA = 4'hA;

    logic            clk = 1'b0;
    logic [5:0]      op_code  = '0;
    logic            cmp_zero = 1'b0;
    logic            irq_req  = 1'b0;
    logic            ill_flag = 1'b0;
    logic [FN_W-1:0] alu_fn;
    logic            rf_we, b_lit_sel, mem_we, rd2_rc_sel, a_pc_sel, wa_xp_sel;
    logic [1:0]      wb_src;
    logic [2:0]      pc_src;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    risc_ctrl_decoder u_risc_ctrl_decoder (
        .op_code    (op_code),
        .cmp_zero   (cmp_zero),
        .irq_req    (irq_req),
        .ill_flag   (ill_flag),
        .alu_fn     (alu_fn),
        .rf_we      (rf_we),
        .b_lit_sel  (b_lit_sel),
        .wb_src     (wb_src),
        .mem_we     (mem_we),
        .rd2_rc_sel (rd2_rc_sel),
        .pc_src     (pc_src),
        .a_pc_sel   (a_pc_sel),
        .wa_xp_sel  (wa_xp_sel)
    );

    // Packed as {alu_fn, rf_we, b_lit, wb[1:0], mem_we, rd2_rc, pc[2:0], a_pc, wa_xp}
    function automatic logic [15:0] pack(input logic [3:0] fn, input logic we,
            input logic bl, input logic [1:0] wb, input logic mw, input logic rc,
            input logic [2:0] pc, input logic ap, input logic xp);
        return {fn, we, bl, wb, mw, rc, pc, ap, xp};
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic z,
                                     input logic irq, input logic ill);
        if (irq)                 return "R10";
        if (ill)                 return "R9";
        if (op >= 6'h30)         return "R3";
        if (op >= 6'h20)         return "R2";
        if (op == 6'h18)         return "R4";
        if (op == 6'h19)         return "R5";
        if (op == 6'h1B)         return "R6";
        if (op == 6'h1C || op == 6'h1D) return z ? "R7" : "R11";
        if (op == 6'h1F)         return "R8";
        return "R1";
    endfunction

    function automatic logic [15:0] expect_vec(input logic [5:0] op, input logic z,
                                              input logic irq, input logic ill);
        if (irq)         return pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd4, 0, 1);   // R10
        if (ill)         return pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd3, 0, 1);   // R9
        if (op >= 6'h30) return pack(op[3:0], 1, 1, 2'd1, 0, 0, 3'd0, 0, 0); // R3
        if (op >= 6'h20) return pack(op[3:0], 1, 0, 2'd1, 0, 0, 3'd0, 0, 0); // R2
        case (op)
            6'h18: return pack(E_ADD, 1, 1, 2'd2, 0, 0, 3'd0, 0, 0);         // R4
            6'h19: return pack(E_ADD, 0, 1, 2'd0, 1, 1, 3'd0, 0, 0);         // R5
            6'h1B: return pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd2, 0, 0);         // R6
            6'h1C: return pack(E_ADD, 1, 0, 2'd0, 0, 0, z ? 3'd1 : 3'd0, 0, 0); // R7
            6'h1D: return pack(E_ADD, 1, 0, 2'd0, 0, 0, z ? 3'd0 : 3'd1, 0, 0); // R7
            6'h1F: return pack(E_PSA, 1, 0, 2'd2, 0, 0, 3'd0, 1, 0);         // R8
            default: return pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd3, 0, 1);       // R1 illegal
        endcase
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    // Sweep: drive after a rising edge, sample on the following falling edge.
    initial begin
        logic [15:0] act, exp_v;
        // Initial state: all-zero inputs decode as an illegal opcode (R1).
        @(negedge clk);
        act = {alu_fn, rf_we, b_lit_sel, wb_src, mem_we, rd2_rc_sel, pc_src, a_pc_sel, wa_xp_sel};
        n_checks++;
        if (act !== pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd3, 0, 1)) begin
            n_errors++;
            $display("FAIL R1 idle: actual=%h expected=%h", act,
                     pack(E_ADD, 1, 0, 2'd0, 0, 0, 3'd3, 0, 1));
        end
        for (int v = 0; v < 512; v++) begin
            @(posedge clk);
            op_code  = v[5:0];
            cmp_zero = v[6];
            ill_flag = v[7];
            irq_req  = v[8];
            @(negedge clk);
            act   = {alu_fn, rf_we, b_lit_sel, wb_src, mem_we, rd2_rc_sel, pc_src, a_pc_sel, wa_xp_sel};
            exp_v = expect_vec(op_code, cmp_zero, irq_req, ill_flag);
            n_checks++;
            if (act !== exp_v) begin
                n_errors++;
                $display("FAIL %s op=%h z=%0d ill=%0d irq=%0d: actual=%h expected=%h",
                         tag_of(op_code, cmp_zero, irq_req, ill_flag),
                         op_code, cmp_zero, ill_flag, irq_req, act, exp_v);
            end
        end
        report();
    end

endmodule